// File: doc/BRIEF.md
# Parallel NOR Command Sequence Decoder

This block sits behind the write port of a flash controller and turns a stream of word-wide bus writes into decoded commands. Each write carries a word address and a 16-bit data value. The decoder follows the multi-write command sequences used by parallel NOR flash. These sequences start with a two-write unlock prefix and then carry an opcode, an address or a payload. When a sequence completes, the decoder raises a one-cycle strobe with a command code and the address and data of the write that completed it.

Some sequences are open-ended. The buffered program sequence has a variable-length payload phase whose length is set by a word count. The erase sequence needs a second unlock prefix. A separate flag records a buffered program that went wrong. That flag stays set until a dedicated recovery sequence clears it. The busy input tells the decoder that an embedded program or erase is running, and a reset request is dropped while busy is high. The decoder does not execute program or erase operations, and it does not drive the physical bus.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, cmdValid is 0, cmdCode is 0 and wbAbort is 0.
- R2: The unlock prefix is data 0x00AA at word offset 0x555, followed by data 0x0055 at offset 0x2AA. After it, 0x00A0 at offset 0x555 arms a word program. The next write then gives cmdCode 1, with that write's address and data on cmdAddr and cmdData. Every strobe appears for one cycle, in the clock cycle after the completing write is sampled.
- R3: After the unlock prefix, 0x0025 at any address selects a sector (address bits above the sector field). The next write to that sector carries N-1, where N-1 is at most 255, and gives cmdCode 2. N data writes follow, and each gives cmdCode 3. Then 0x0029 to the same sector gives cmdCode 4.
- R4: wbAbort is set and no command is issued in three cases: the word count exceeds 255; a data write falls outside the 256-word window of the first data word; or the write after the last data word is not 0x0029 to the selected sector.
- R5: Only the unlock prefix followed by 0x00F0 at offset 0x555 clears wbAbort. It issues cmdCode 13. A plain 0x00F0 leaves wbAbort unchanged.
- R6: The unlock prefix, then 0x0080 at 0x555, then a second unlock prefix, followed by 0x0030 at any address, gives cmdCode 5 (sector erase). If 0x0010 at 0x555 comes instead of 0x0030, the result is cmdCode 6 (chip erase).
- R7: After the unlock prefix, 0x0090 at 0x555 gives cmdCode 7 (identification overlay). A single write of 0x0098 at offset 0x055 from idle gives cmdCode 8 (parameter table overlay).
- R8: After the unlock prefix, a write at offset 0x555 of any sector gives a command: 0x0070 gives cmdCode 9 (status read), 0x0033 gives cmdCode 10 (blank check), and 0x00D0 gives cmdCode 11 (erase status evaluation). Offsets are the low 12 word-address bits.
- R9: A 0x00F0 write gives cmdCode 12 when busy is low. This applies in idle, after the first unlock write, after the full prefix at an offset other than 0x555, and in the erase prefix states. While busy is high, any 0x00F0 write (including the recovery form of R5) issues nothing.
- R10: An unexpected address or data value in the middle of a sequence returns the decoder to idle without a command. This includes a count write to a different sector. Writes that follow are then decoded from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write cycle strobe, one word per cycle |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | 16 | Data of the write |
| busy | input | 1 | Embedded program or erase in progress |
| cmdValid | output | 1 | One-cycle decoded command strobe |
| cmdCode | output | 4 | Decoded command code (see requirements) |
| cmdAddr | output | ADDR_W | Address of the write that completed the command |
| cmdData | output | 16 | Data of the write that completed the command |
| wbAbort | output | 1 | Buffered program sequence failure flag |

## Verification
On every cycle, the assertions check the following properties. A strobe always carries a nonzero code and always follows a sampled write. A reset command never follows a busy write. The abort flag rises without a command and falls only together with the recovery code. A chip erase strobe always follows a 0x0010 write. The bench scenarios cover the rest. These are the full opcode sequences, the 256-word buffer at its count limit, a count overflow, window and confirm violations, broken prefixes that must fall back to idle, and the difference between a plain reset and the recovery sequence on the abort flag.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMD_AW = 12;

  localparam logic [CMD_AW-1:0] OFS_UNLOCK_A = 12'h555;
  localparam logic [CMD_AW-1:0] OFS_UNLOCK_B = 12'h2AA;
  localparam logic [CMD_AW-1:0] OFS_QUERY    = 12'h055;

  localparam logic [15:0] OP_KEY_A     = 16'h00AA;
  localparam logic [15:0] OP_KEY_B     = 16'h0055;
  localparam logic [15:0] OP_PROG      = 16'h00A0;
  localparam logic [15:0] OP_BUF_LOAD  = 16'h0025;
  localparam logic [15:0] OP_BUF_GO    = 16'h0029;
  localparam logic [15:0] OP_ERS_SETUP = 16'h0080;
  localparam logic [15:0] OP_ERS_SECT  = 16'h0030;
  localparam logic [15:0] OP_ERS_CHIP  = 16'h0010;
  localparam logic [15:0] OP_ID        = 16'h0090;
  localparam logic [15:0] OP_QUERY     = 16'h0098;
  localparam logic [15:0] OP_STATUS    = 16'h0070;
  localparam logic [15:0] OP_BLANK     = 16'h0033;
  localparam logic [15:0] OP_EVAL      = 16'h00D0;
  localparam logic [15:0] OP_RESET     = 16'h00F0;

  typedef enum logic [3:0] {
    CMD_NONE        = 4'd0,
    CMD_WORD_PROG   = 4'd1,
    CMD_BUF_START   = 4'd2,
    CMD_BUF_WORD    = 4'd3,
    CMD_BUF_CONFIRM = 4'd4,
    CMD_SECT_ERASE  = 4'd5,
    CMD_CHIP_ERASE  = 4'd6,
    CMD_ID_ENTER    = 4'd7,
    CMD_QUERY_ENTER = 4'd8,
    CMD_STATUS_READ = 4'd9,
    CMD_BLANK_CHECK = 4'd10,
    CMD_ERASE_EVAL  = 4'd11,
    CMD_RESET       = 4'd12,
    CMD_ABORT_RESET = 4'd13
  } cmd_code_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_KEY1, ST_OPCODE, ST_PROG, ST_BUF_CNT, ST_BUF_FIRST,
    ST_BUF_MORE, ST_BUF_CONF, ST_ERS_A, ST_ERS_B, ST_ERS_C
  } seq_state_e;

  typedef struct packed {
    logic      emit;
    cmd_code_e code;
    logic      loadSector;
    logic      loadCount;
    logic      decCount;
    logic      loadWindow;
    logic      setAbort;
    logic      clrAbort;
  } ctrl_strobe_t;

  typedef struct packed {
    logic atKeyA;
    logic atKeyB;
    logic atQuery;
    logic sameSector;
    logic sameWindow;
    logic countFits;
    logic countZero;
  } dp_flags_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [15:0]  wrData,
  input  logic         busy,
  input  dp_flags_t    flags,
  output ctrl_strobe_t strobe
);

  seq_state_e state, nxtState;
  logic isReset, resetOk;

  assign isReset = (wrData == OP_RESET);
  assign resetOk = isReset && !busy;

  always_comb begin
    strobe   = '0;
    nxtState = state;
    if (wrEn) begin
      nxtState = ST_IDLE;
      case (state)
        ST_IDLE: begin
          if (flags.atKeyA && wrData == OP_KEY_A) begin
            nxtState = ST_KEY1;
          end else if (flags.atQuery && wrData == OP_QUERY) begin
            strobe.emit = 1'b1; strobe.code = CMD_QUERY_ENTER;
          end else if (resetOk) begin
            strobe.emit = 1'b1; strobe.code = CMD_RESET;
          end
        end
        ST_KEY1: begin
          if (flags.atKeyB && wrData == OP_KEY_B) begin
            nxtState = ST_OPCODE;
          end else if (resetOk) begin
            strobe.emit = 1'b1; strobe.code = CMD_RESET;
          end
        end
        ST_OPCODE: begin
          if (wrData == OP_BUF_LOAD) begin
            nxtState          = ST_BUF_CNT;
            strobe.loadSector = 1'b1;
          end else if (isReset) begin
            if (!busy) begin
              strobe.emit     = 1'b1;
              strobe.code     = flags.atKeyA ? CMD_ABORT_RESET : CMD_RESET;
              strobe.clrAbort = flags.atKeyA;
            end
          end else if (flags.atKeyA) begin
            case (wrData)
              OP_PROG:      nxtState = ST_PROG;
              OP_ERS_SETUP: nxtState = ST_ERS_A;
              OP_ID:     begin strobe.emit = 1'b1; strobe.code = CMD_ID_ENTER;    end
              OP_STATUS: begin strobe.emit = 1'b1; strobe.code = CMD_STATUS_READ; end
              OP_BLANK:  begin strobe.emit = 1'b1; strobe.code = CMD_BLANK_CHECK; end
              OP_EVAL:   begin strobe.emit = 1'b1; strobe.code = CMD_ERASE_EVAL;  end
              default: ;
            endcase
          end
        end
        ST_PROG: begin
          strobe.emit = 1'b1; strobe.code = CMD_WORD_PROG;
        end
        ST_BUF_CNT: begin
          if (flags.sameSector) begin
            if (flags.countFits) begin
              strobe.loadCount = 1'b1;
              strobe.emit      = 1'b1;
              strobe.code      = CMD_BUF_START;
              nxtState         = ST_BUF_FIRST;
            end else begin
              strobe.setAbort = 1'b1;
            end
          end
        end
        ST_BUF_FIRST: begin
          if (flags.sameSector) begin
            strobe.loadWindow = 1'b1;
            strobe.emit       = 1'b1;
            strobe.code       = CMD_BUF_WORD;
            if (flags.countZero) begin
              nxtState = ST_BUF_CONF;
            end else begin
              strobe.decCount = 1'b1;
              nxtState        = ST_BUF_MORE;
            end
          end else begin
            strobe.setAbort = 1'b1;
          end
        end
        ST_BUF_MORE: begin
          if (flags.sameWindow) begin
            strobe.emit = 1'b1;
            strobe.code = CMD_BUF_WORD;
            if (flags.countZero) begin
              nxtState = ST_BUF_CONF;
            end else begin
              strobe.decCount = 1'b1;
              nxtState        = ST_BUF_MORE;
            end
          end else begin
            strobe.setAbort = 1'b1;
          end
        end
        ST_BUF_CONF: begin
          if (flags.sameSector && wrData == OP_BUF_GO) begin
            strobe.emit = 1'b1; strobe.code = CMD_BUF_CONFIRM;
          end else begin
            strobe.setAbort = 1'b1;
          end
        end
        ST_ERS_A: begin
          if (flags.atKeyA && wrData == OP_KEY_A) begin
            nxtState = ST_ERS_B;
          end else if (resetOk) begin
            strobe.emit = 1'b1; strobe.code = CMD_RESET;
          end
        end
        ST_ERS_B: begin
          if (flags.atKeyB && wrData == OP_KEY_B) begin
            nxtState = ST_ERS_C;
          end else if (resetOk) begin
            strobe.emit = 1'b1; strobe.code = CMD_RESET;
          end
        end
        ST_ERS_C: begin
          if (wrData == OP_ERS_SECT) begin
            strobe.emit = 1'b1; strobe.code = CMD_SECT_ERASE;
          end else if (flags.atKeyA && wrData == OP_ERS_CHIP) begin
            strobe.emit = 1'b1; strobe.code = CMD_CHIP_ERASE;
          end else if (resetOk) begin
            strobe.emit = 1'b1; strobe.code = CMD_RESET;
          end
        end
        default: nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int SECTOR_LSB = 17,
  parameter int BUF_AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  ctrl_strobe_t      strobe,
  output dp_flags_t         flags,
  output logic              cmdValid,
  output logic [3:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [15:0]       cmdData,
  output logic              wbAbort
);

  localparam int SECT_W = ADDR_W - SECTOR_LSB;
  localparam int WIN_W  = ADDR_W - BUF_AW;

  logic [SECT_W-1:0] sectorQ;
  logic [WIN_W-1:0]  windowQ;
  logic [BUF_AW-1:0] countQ;

  assign flags.atKeyA     = (wrAddr[CMD_AW-1:0] == OFS_UNLOCK_A);
  assign flags.atKeyB     = (wrAddr[CMD_AW-1:0] == OFS_UNLOCK_B);
  assign flags.atQuery    = (wrAddr[CMD_AW-1:0] == OFS_QUERY);
  assign flags.sameSector = (wrAddr[ADDR_W-1:SECTOR_LSB] == sectorQ);
  assign flags.sameWindow = (wrAddr[ADDR_W-1:BUF_AW] == windowQ);
  assign flags.countFits  = ((wrData >> BUF_AW) == 16'd0);
  assign flags.countZero  = (countQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectorQ <= '0;
      windowQ <= '0;
      countQ  <= '0;
    end else begin
      if (strobe.loadSector) sectorQ <= wrAddr[ADDR_W-1:SECTOR_LSB];
      if (strobe.loadWindow) windowQ <= wrAddr[ADDR_W-1:BUF_AW];
      if (strobe.loadCount)     countQ <= wrData[BUF_AW-1:0];
      else if (strobe.decCount) countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdCode  <= CMD_NONE;
      cmdAddr  <= '0;
      cmdData  <= '0;
      wbAbort  <= 1'b0;
    end else begin
      cmdValid <= strobe.emit;
      cmdCode  <= strobe.emit ? strobe.code : CMD_NONE;
      if (strobe.emit) begin
        cmdAddr <= wrAddr;
        cmdData <= wrData;
      end
      if (strobe.setAbort)      wbAbort <= 1'b1;
      else if (strobe.clrAbort) wbAbort <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int SECTOR_LSB = 17,
  parameter int BUF_AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              busy,
  output logic              cmdValid,
  output logic [3:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [15:0]       cmdData,
  output logic              wbAbort
);

  ctrl_strobe_t strobe;
  dp_flags_t    flags;

  flash_cmd_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .busy   (busy),
    .flags  (flags),
    .strobe (strobe)
  );

  flash_cmd_dp #(
    .ADDR_W     (ADDR_W),
    .SECTOR_LSB (SECTOR_LSB),
    .BUF_AW     (BUF_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobe   (strobe),
    .flags    (flags),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .wbAbort  (wbAbort)
  );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
  import flash_cmd_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic        busy,
  input logic        cmdValid,
  input logic [3:0]  cmdCode,
  input logic        wbAbort
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!cmdValid && !wbAbort));

  assert_code_present_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCode != CMD_NONE));

  assert_after_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(wrEn));

  assert_abort_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbAbort) |-> !cmdValid);

  assert_abort_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wbAbort) |-> (cmdValid && cmdCode == CMD_ABORT_RESET));

  assert_chip_opcode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_CHIP_ERASE) |-> ($past(wrData) == OP_ERS_CHIP));

  assert_reset_not_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdCode == CMD_RESET || cmdCode == CMD_ABORT_RESET)) |-> !$past(busy));

endmodule

bind flash_cmd_decoder flash_cmd_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .busy     (busy),
  .cmdValid (cmdValid),
  .cmdCode  (cmdCode),
  .wbAbort  (wbAbort)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int ADDR_W = 25;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrEn;
  logic [ADDR_W-1:0] wrAddr;
  logic [15:0]       wrData;
  logic              busy;
  logic              cmdValid;
  logic [3:0]        cmdCode;
  logic [ADDR_W-1:0] cmdAddr;
  logic [15:0]       cmdData;
  logic              wbAbort;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .wbAbort(wbAbort)
  );

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [24:0] a;
    logic [15:0] d;
    logic        b;
    logic        v;
    logic [3:0]  c;
    logic        ab;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 57;
  localparam vec_t VEC [NV] = '{
    // R2 word program
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd2},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd2},
    '{25'h555, 16'h00A0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd2},
    '{25'h12345, 16'hBEEF, 1'b0, 1'b1, 4'd1, 1'b0, 4'd2},
    // R6 sector erase
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h555, 16'h0080, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h0A0000, 16'h0030, 1'b0, 1'b1, 4'd5, 1'b0, 4'd6},
    // R6 chip erase
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h555, 16'h0080, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd6},
    '{25'h555, 16'h0010, 1'b0, 1'b1, 4'd6, 1'b0, 4'd6},
    // R7 identification and query overlays
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd7},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd7},
    '{25'h555, 16'h0090, 1'b0, 1'b1, 4'd7, 1'b0, 4'd7},
    '{25'h055, 16'h0098, 1'b0, 1'b1, 4'd8, 1'b0, 4'd7},
    // R8 status, blank check, erase evaluation
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd8},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd8},
    '{25'h555, 16'h0070, 1'b0, 1'b1, 4'd9, 1'b0, 4'd8},
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd8},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd8},
    '{25'h040555, 16'h0033, 1'b0, 1'b1, 4'd10, 1'b0, 4'd8},
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd8},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd8},
    '{25'h040555, 16'h00D0, 1'b0, 1'b1, 4'd11, 1'b0, 4'd8},
    // R9 reset, idle and busy
    '{25'h000123, 16'h00F0, 1'b0, 1'b1, 4'd12, 1'b0, 4'd9},
    '{25'h000123, 16'h00F0, 1'b1, 1'b0, 4'd0, 1'b0, 4'd9},
    // R10 broken prefix
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd10},
    '{25'h2AA, 16'h0066, 1'b0, 1'b0, 4'd0, 1'b0, 4'd10},
    '{25'h555, 16'h00A0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd10},
    '{25'h000100, 16'h1234, 1'b0, 1'b0, 4'd0, 1'b0, 4'd10},
    // R3 buffered program of three words
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd3},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd3},
    '{25'h040000, 16'h0025, 1'b0, 1'b0, 4'd0, 1'b0, 4'd3},
    '{25'h040010, 16'h0002, 1'b0, 1'b1, 4'd2, 1'b0, 4'd3},
    '{25'h040100, 16'h0001, 1'b0, 1'b1, 4'd3, 1'b0, 4'd3},
    '{25'h040101, 16'h0002, 1'b0, 1'b1, 4'd3, 1'b0, 4'd3},
    '{25'h0401FF, 16'h0003, 1'b0, 1'b1, 4'd3, 1'b0, 4'd3},
    '{25'h040000, 16'h0029, 1'b0, 1'b1, 4'd4, 1'b0, 4'd3},
    // R4 window break
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd4},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd4},
    '{25'h040000, 16'h0025, 1'b0, 1'b0, 4'd0, 1'b0, 4'd4},
    '{25'h040000, 16'h0001, 1'b0, 1'b1, 4'd2, 1'b0, 4'd4},
    '{25'h040100, 16'hAAAA, 1'b0, 1'b1, 4'd3, 1'b0, 4'd4},
    '{25'h040200, 16'hBBBB, 1'b0, 1'b0, 4'd0, 1'b1, 4'd4},
    // R5 plain reset keeps the flag, recovery clears it
    '{25'h000000, 16'h00F0, 1'b0, 1'b1, 4'd12, 1'b1, 4'd5},
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b1, 4'd5},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b1, 4'd5},
    '{25'h555, 16'h00F0, 1'b0, 1'b1, 4'd13, 1'b0, 4'd5},
    // R10 count written to another sector
    '{25'h555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 4'd10},
    '{25'h2AA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 4'd10},
    '{25'h040000, 16'h0025, 1'b0, 1'b0, 4'd0, 1'b0, 4'd10},
    '{25'h080000, 16'h0000, 1'b0, 1'b0, 4'd0, 1'b0, 4'd10}
  };

  task automatic put(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    wrAddr = a; wrData = d; busy = b; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; busy = 1'b0;
  endtask

  task automatic unlock();
    put(25'h555, 16'h00AA, 1'b0);
    put(25'h2AA, 16'h0055, 1'b0);
  endtask

  task automatic checkOut(input string req, input logic ev, input logic [3:0] ec,
                          input logic ea, input logic [ADDR_W-1:0] xa, input logic [15:0] xd);
    checks++;
    if (cmdValid !== ev || wbAbort !== ea ||
        (ev && (cmdCode !== ec || cmdAddr !== xa || cmdData !== xd))) begin
      failures++;
      $display("FAIL %s: valid=%b code=%0d abort=%b addr=%h data=%h, expected valid=%b code=%0d abort=%b addr=%h data=%h",
               req, cmdValid, cmdCode, wbAbort, cmdAddr, cmdData, ev, ec, ea, xa, xd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bad;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; busy = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (cmdValid !== 1'b0 || cmdCode !== 4'd0 || wbAbort !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: valid=%b code=%0d abort=%b, expected 0 0 0", cmdValid, cmdCode, wbAbort);
    end
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 1'b0, 4'd0, 1'b0, '0, '0);

    for (int i = 0; i < NV; i++) begin
      put(VEC[i].a, VEC[i].d, VEC[i].b);
      checkOut($sformatf("R%0d vector %0d", VEC[i].r, i), VEC[i].v, VEC[i].c,
               VEC[i].ab, VEC[i].a, VEC[i].d);
    end

    // R3 full 256-word buffer at the count limit
    unlock();
    put(25'h080000, 16'h0025, 1'b0);
    put(25'h080000, 16'h00FF, 1'b0);
    checkOut("R3 count 255 start", 1'b1, 4'd2, 1'b0, 25'h080000, 16'h00FF);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      put(25'h080300 + i, 16'(i), 1'b0);
      if (cmdValid !== 1'b1 || cmdCode !== 4'd3 || cmdData !== 16'(i)) bad++;
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL R3 256 data words: bad words=%0d, expected 0", bad);
    end
    put(25'h080000, 16'h0029, 1'b0);
    checkOut("R3 confirm after 256 words", 1'b1, 4'd4, 1'b0, 25'h080000, 16'h0029);

    // R4 count overflow
    unlock();
    put(25'h040000, 16'h0025, 1'b0);
    put(25'h040000, 16'h0100, 1'b0);
    checkOut("R4 count overflow", 1'b0, 4'd0, 1'b1, '0, '0);

    // R9 recovery ignored while busy
    unlock();
    put(25'h555, 16'h00F0, 1'b1);
    checkOut("R9 recovery while busy", 1'b0, 4'd0, 1'b1, '0, '0);

    // R5 recovery clears
    unlock();
    put(25'h555, 16'h00F0, 1'b0);
    checkOut("R5 recovery", 1'b1, 4'd13, 1'b0, 25'h555, 16'h00F0);

    // R4 bad confirm
    unlock();
    put(25'h040000, 16'h0025, 1'b0);
    put(25'h040000, 16'h0000, 1'b0);
    checkOut("R3 single-word start", 1'b1, 4'd2, 1'b0, 25'h040000, 16'h0000);
    put(25'h040005, 16'h1234, 1'b0);
    checkOut("R3 single data word", 1'b1, 4'd3, 1'b0, 25'h040005, 16'h1234);
    put(25'h040000, 16'h0030, 1'b0);
    checkOut("R4 wrong confirm", 1'b0, 4'd0, 1'b1, '0, '0);
    unlock();
    put(25'h555, 16'h00F0, 1'b0);
    checkOut("R5 recovery after confirm error", 1'b1, 4'd13, 1'b0, 25'h555, 16'h00F0);

    // R9 reset after the first unlock write
    put(25'h555, 16'h00AA, 1'b0);
    put(25'h2AA, 16'h00F0, 1'b0);
    checkOut("R9 reset mid prefix", 1'b1, 4'd12, 1'b0, 25'h2AA, 16'h00F0);

    // R10 broken erase prefix, then a stray sector-erase opcode
    unlock();
    put(25'h555, 16'h0080, 1'b0);
    put(25'h555, 16'h00AA, 1'b0);
    put(25'h2AA, 16'h0012, 1'b0);
    checkOut("R10 broken erase prefix", 1'b0, 4'd0, 1'b0, '0, '0);
    put(25'h000000, 16'h0030, 1'b0);
    checkOut("R10 stray opcode from idle", 1'b0, 4'd0, 1'b0, '0, '0);

    // R2 strobe lasts one cycle
    unlock();
    put(25'h555, 16'h00A0, 1'b0);
    put(25'h000777, 16'h5A5A, 1'b0);
    checkOut("R2 program strobe", 1'b1, 4'd1, 1'b0, 25'h000777, 16'h5A5A);
    @(negedge clk);
    checkOut("R2 strobe drops", 1'b0, 4'd0, 1'b0, '0, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule